// File: doc/BRIEF.md
# Dual-Format Register Control Port

This block is a slave register port through which a host loads a small bank of configuration registers. The same pins carry either an I2C transfer or a four-wire SPI-style transfer. After reset the port runs as an I2C slave and the address/chip-select pin is a static low address bit. The first high-to-low transition on that pin switches the port to SPI framing, and it stays in SPI until the next reset. The bus pins may toggle with no relation to any audio timing. All bus inputs are oversampled in the system clock domain through two-flop synchronizers.

A write carries a pointer byte and then data bytes. The pointer byte holds a 4-bit register address and an auto-increment flag. The bank decodes 16 addresses, but only the lowest `NUM_REGS` of them hold storage. One bit of one register is the port-enable flag, which is brought out as `cp_en`. While that flag is clear, the surrounding chip treats the shared pins as stand-alone strap inputs.

Top module: `ctrl_port_slave`

## Requirements
- R1: After reset every register reads 0, the pointer and the auto-increment flag are 0, `sda_oe` and `spi_dout` are 0, `cp_en` is 0 and `spi_sel` is 0 (I2C mode).
- R2: In I2C mode the slave answers only the 7-bit address whose bits 6..2 are 10011, whose bit 1 is `ad1` and whose bit 0 is `ad0_cs`. It pulls SDA low in the acknowledge slot after a matching address byte. It gives no acknowledge for any other address, and such a transfer changes no register.
- R3: In an I2C write, the byte after the address byte is the pointer byte and the bytes after it are data bytes. The slave acknowledges each of them.
- R4: Pointer byte layout: bit 7 is auto-increment, bits 6..4 are ignored, bits 3..0 are the register address. With auto-increment at 0 the pointer keeps its value across data bytes. With it at 1 the pointer steps by one after each data byte written or read, and it wraps from 15 to 0.
- R5: An I2C read (R/W bit = 1) returns the register at the current pointer, MSB first, using the same increment rule. A repeated start between the pointer write and the read is accepted. The host's acknowledge continues the burst and its not-acknowledge ends it.
- R6: Writes to addresses at or above `NUM_REGS` change nothing, and reads from them return 0.
- R7: A falling edge on `ad0_cs` sets `spi_sel` to 1, and it stays 1 until reset. A rising edge alone does not set it. In SPI mode, I2C traffic on the shared pins gets no acknowledge and writes nothing.
- R8: An SPI frame is framed by `ad0_cs` low. Bytes are sent MSB first and sampled on the rising edge of `scl`. The first byte is a chip address whose bits 7..3 are 10011, bit 2 is `ad1`, bit 1 is 0 and bit 0 is R/W. With R/W = 0 the pointer byte follows, then data bytes. A frame with any other chip address is ignored.
- R9: In an SPI frame with R/W = 1, the register at the current pointer is shifted out on `spi_dout` MSB first. Each bit changes after a falling edge of `scl`, so the host samples it at the next rising edge. Bytes follow one another under the increment rule of R4.
- R10: `cp_en` equals bit 7 of register 7 and changes only through a data write to that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl | input | 1 | I2C clock, or SPI serial clock |
| sda_in | input | 1 | Level of the I2C data line, or SPI serial data in |
| sda_oe | output | 1 | Pulls the open-drain data line low when 1 |
| ad0_cs | input | 1 | I2C address bit 0, or SPI chip select (active low) |
| ad1 | input | 1 | Address bit used by both formats |
| spi_dout | output | 1 | SPI serial data out |
| spi_sel | output | 1 | 1 once SPI framing has been selected |
| cp_en | output | 1 | Port-enable flag from the register bank |
| cfg_regs | output | NUM_REGS*8 | Contents of all implemented registers; register k in bits 8k+7..8k |

## Verification
The assertions assume that the bus inputs are well-formed. The data line changes only while the clock is low, except at start and stop conditions. No bus pin changes twice within the four cycles of synchronizer and edge-detect latency. `ad0_cs` stays static during an I2C transfer. The bench drives every bus phase for twelve system clocks, sets data only with the clock low, and raises chip select only between I2C transfers. That keeps every edge the design detects separate from the next and keeps the internal pulses the checker watches well defined.

// File: rtl/cps_pkg.sv
// Shared constants and state types for the dual-format control port.
// Assumes a 16-slot register address space (4-bit pointer).
package cps_pkg;
    localparam int          SLOTS      = 16;
    localparam int          PTR_W      = $clog2(SLOTS);
    localparam logic [4:0]  DEV_PREFIX = 5'b10011;

    typedef enum logic [2:0] {
        I2C_IDLE,
        I2C_RX,
        I2C_ACK,
        I2C_TX,
        I2C_MACK
    } i2c_st_e;
endpackage

// File: rtl/cps_sync.sv
// Multi-stage synchronizer bringing asynchronous bus pins into clk.
// Assumes inputs are single-bit independent levels; resets to 0.
module cps_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    // shift each pin through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/cps_i2c.sv
// I2C slave byte engine. Detects start/stop, receives address and
// write bytes, drives ACK and read data onto the open-drain line.
// Assumes synchronized levels and one-cycle edge pulses from the top;
// held in reset while en is low.
module cps_i2c
    import cps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       scl_lv,
    input  logic       sda_lv,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_rise,
    input  logic       sda_fall,
    input  logic [6:0] dev_addr,
    input  logic [7:0] rdata,
    output logic       sda_oe,
    output logic       ptr_wr,
    output logic       dat_wr,
    output logic       rd_adv,
    output logic [7:0] wdata
);
    i2c_st_e    st_q;
    logic [2:0] bitcnt_q;
    logic [7:0] sh_q, tx_q;
    logic       got_q, is_addr_q, first_q, rw_q, mack_q;
    logic       start_ev, stop_ev;

    assign start_ev = sda_fall && scl_lv;
    assign stop_ev  = sda_rise && scl_lv;

    // bit-level sequencing: sample on SCL rise, drive on SCL fall
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            st_q      <= I2C_IDLE;
            bitcnt_q  <= '0;
            sh_q      <= '0;
            tx_q      <= '0;
            got_q     <= 1'b0;
            is_addr_q <= 1'b0;
            first_q   <= 1'b0;
            rw_q      <= 1'b0;
            mack_q    <= 1'b0;
            sda_oe    <= 1'b0;
            ptr_wr    <= 1'b0;
            dat_wr    <= 1'b0;
            rd_adv    <= 1'b0;
            wdata     <= '0;
        end else begin
            ptr_wr <= 1'b0;
            dat_wr <= 1'b0;
            rd_adv <= 1'b0;
            if (start_ev) begin
                st_q      <= I2C_RX;
                is_addr_q <= 1'b1;
                first_q   <= 1'b1;
                bitcnt_q  <= '0;
                got_q     <= 1'b0;
                sda_oe    <= 1'b0;
            end else if (stop_ev) begin
                st_q   <= I2C_IDLE;
                sda_oe <= 1'b0;
            end else if (scl_rise) begin
                case (st_q)
                    I2C_RX: begin
                        sh_q     <= {sh_q[6:0], sda_lv};
                        bitcnt_q <= bitcnt_q + 3'd1;
                        if (bitcnt_q == 3'd7) got_q <= 1'b1;
                    end
                    I2C_TX: begin
                        bitcnt_q <= bitcnt_q + 3'd1;
                        if (bitcnt_q == 3'd7) got_q <= 1'b1;
                    end
                    I2C_MACK: mack_q <= !sda_lv;
                    default: ;
                endcase
            end else if (scl_fall) begin
                case (st_q)
                    I2C_RX: begin
                        if (got_q) begin
                            got_q <= 1'b0;
                            if (is_addr_q) begin
                                if (sh_q[7:1] == dev_addr) begin
                                    sda_oe <= 1'b1;
                                    rw_q   <= sh_q[0];
                                    st_q   <= I2C_ACK;
                                end else begin
                                    st_q <= I2C_IDLE;
                                end
                            end else begin
                                sda_oe  <= 1'b1;
                                st_q    <= I2C_ACK;
                                wdata   <= sh_q;
                                ptr_wr  <= first_q;
                                dat_wr  <= !first_q;
                                first_q <= 1'b0;
                            end
                        end
                    end
                    I2C_ACK: begin
                        is_addr_q <= 1'b0;
                        bitcnt_q  <= '0;
                        if (rw_q) begin
                            tx_q   <= {rdata[6:0], 1'b0};
                            sda_oe <= !rdata[7];
                            st_q   <= I2C_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            st_q   <= I2C_RX;
                        end
                    end
                    I2C_TX: begin
                        if (got_q) begin
                            got_q  <= 1'b0;
                            sda_oe <= 1'b0;
                            rd_adv <= 1'b1;
                            st_q   <= I2C_MACK;
                        end else begin
                            sda_oe <= !tx_q[7];
                            tx_q   <= {tx_q[6:0], 1'b0};
                        end
                    end
                    I2C_MACK: begin
                        if (mack_q) begin
                            tx_q     <= {rdata[6:0], 1'b0};
                            sda_oe   <= !rdata[7];
                            bitcnt_q <= '0;
                            st_q     <= I2C_TX;
                        end else begin
                            st_q <= I2C_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/cps_spi.sv
// SPI-style frame engine: chip address byte (R/W last), pointer byte,
// then data; or read data shifted out after falling clock edges.
// Assumes synchronized levels and edge pulses; idle while cs is high.
module cps_spi (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       cs_lv,
    input  logic       mosi_lv,
    input  logic       sck_rise,
    input  logic       sck_fall,
    input  logic [6:0] dev_addr,
    input  logic [7:0] rdata,
    output logic       miso,
    output logic       ptr_wr,
    output logic       dat_wr,
    output logic       rd_adv,
    output logic [7:0] wdata
);
    logic [7:0] sh_q, tx_q, sh_nx;
    logic [2:0] bitcnt_q, txcnt_q;
    logic [1:0] bidx_q;
    logic       rd_q, drop_q, active;

    assign active = en && !cs_lv;
    assign sh_nx  = {sh_q[6:0], mosi_lv};

    // frame decode on rising edges, read shifting on falling edges
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            sh_q     <= '0;
            tx_q     <= '0;
            bitcnt_q <= '0;
            txcnt_q  <= '0;
            bidx_q   <= '0;
            rd_q     <= 1'b0;
            drop_q   <= 1'b0;
            miso     <= 1'b0;
            ptr_wr   <= 1'b0;
            dat_wr   <= 1'b0;
            rd_adv   <= 1'b0;
            wdata    <= '0;
        end else begin
            ptr_wr <= 1'b0;
            dat_wr <= 1'b0;
            rd_adv <= 1'b0;
            if (sck_rise && !drop_q) begin
                sh_q     <= sh_nx;
                bitcnt_q <= bitcnt_q + 3'd1;
                if (bitcnt_q == 3'd7) begin
                    if (bidx_q == 2'd0) begin
                        if (sh_nx[7:1] == dev_addr) rd_q <= sh_nx[0];
                        else drop_q <= 1'b1;
                    end else if (!rd_q) begin
                        wdata  <= sh_nx;
                        ptr_wr <= (bidx_q == 2'd1);
                        dat_wr <= (bidx_q != 2'd1);
                    end
                    if (bidx_q != 2'd2) bidx_q <= bidx_q + 2'd1;
                end
            end
            if (sck_fall && rd_q) begin
                if (txcnt_q == 3'd0) begin
                    miso <= rdata[7];
                    tx_q <= {rdata[6:0], 1'b0};
                end else begin
                    miso <= tx_q[7];
                    tx_q <= {tx_q[6:0], 1'b0};
                end
                if (txcnt_q == 3'd7) rd_adv <= 1'b1;
                txcnt_q <= txcnt_q + 3'd1;
            end
        end
    end
endmodule

// File: rtl/cps_regbank.sv
// Register bank with address pointer and auto-increment flag.
// Slots at or above NUM_REGS have no storage and are write-ignored.
module cps_regbank
    import cps_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ptr_wr,
    input  logic                  dat_wr,
    input  logic                  rd_adv,
    input  logic [7:0]            wdata,
    output logic [PTR_W-1:0]      ptr,
    output logic [NUM_REGS*8-1:0] regs
);
    logic                inc_q;
    logic [NUM_REGS-1:0] we;

    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_we
            assign we[g] = dat_wr && (ptr == PTR_W'(g));
        end
    endgenerate

    // pointer load from pointer byte, step after each data transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr   <= '0;
            inc_q <= 1'b0;
        end else if (ptr_wr) begin
            ptr   <= wdata[PTR_W-1:0];
            inc_q <= wdata[7];
        end else if ((dat_wr || rd_adv) && inc_q) begin
            ptr <= ptr + 1'b1;
        end
    end

    // register storage, one write enable per implemented slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= '0;
        end else begin
            for (int k = 0; k < NUM_REGS; k++)
                if (we[k]) regs[k*8 +: 8] <= wdata;
        end
    end
endmodule

// File: rtl/ctrl_port_slave.sv
// Top: synchronizes bus pins, selects I2C or SPI format (SPI latched on
// the first chip-select fall), and routes the active engine to the bank.
// Assumes clk runs several times faster than any bus phase.
module ctrl_port_slave
    import cps_pkg::*;
#(
    parameter int NUM_REGS    = 8,
    parameter int CPEN_ADDR   = 7,
    parameter int CPEN_BIT    = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl,
    input  logic                  sda_in,
    output logic                  sda_oe,
    input  logic                  ad0_cs,
    input  logic                  ad1,
    output logic                  spi_dout,
    output logic                  spi_sel,
    output logic                  cp_en,
    output logic [NUM_REGS*8-1:0] cfg_regs
);
    logic [2:0]       pin_s, pin_prev_q;
    logic             scl_s, sda_s, cs_s;
    logic             scl_rise, scl_fall, sda_rise, sda_fall, cs_fall;
    logic             i_ptr_wr, i_dat_wr, i_rd_adv;
    logic             s_ptr_wr, s_dat_wr, s_rd_adv;
    logic [7:0]       i_wdata, s_wdata;
    logic             bus_ptr_wr, bus_dat_wr, bus_rd_adv;
    logic [7:0]       bus_wdata, rd_byte;
    logic [PTR_W-1:0] cur_ptr;

    cps_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({ad0_cs, sda_in, scl}), .q(pin_s)
    );

    assign {cs_s, sda_s, scl_s} = pin_s;

    // previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) pin_prev_q <= '0;
        else        pin_prev_q <= pin_s;
    end

    assign scl_rise = scl_s  && !pin_prev_q[0];
    assign scl_fall = !scl_s && pin_prev_q[0];
    assign sda_rise = sda_s  && !pin_prev_q[1];
    assign sda_fall = !sda_s && pin_prev_q[1];
    assign cs_fall  = !cs_s  && pin_prev_q[2];

    // format latch: SPI once chip select falls, until reset
    always_ff @(posedge clk) begin
        if (!rst_n)       spi_sel <= 1'b0;
        else if (cs_fall) spi_sel <= 1'b1;
    end

    cps_i2c u_i2c (
        .clk(clk), .rst_n(rst_n), .en(!spi_sel),
        .scl_lv(scl_s), .sda_lv(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_rise(sda_rise), .sda_fall(sda_fall),
        .dev_addr({DEV_PREFIX, ad1, cs_s}), .rdata(rd_byte),
        .sda_oe(sda_oe), .ptr_wr(i_ptr_wr), .dat_wr(i_dat_wr),
        .rd_adv(i_rd_adv), .wdata(i_wdata)
    );

    cps_spi u_spi (
        .clk(clk), .rst_n(rst_n), .en(spi_sel),
        .cs_lv(cs_s), .mosi_lv(sda_s),
        .sck_rise(scl_rise), .sck_fall(scl_fall),
        .dev_addr({DEV_PREFIX, ad1, 1'b0}), .rdata(rd_byte),
        .miso(spi_dout), .ptr_wr(s_ptr_wr), .dat_wr(s_dat_wr),
        .rd_adv(s_rd_adv), .wdata(s_wdata)
    );

    assign bus_ptr_wr = spi_sel ? s_ptr_wr : i_ptr_wr;
    assign bus_dat_wr = spi_sel ? s_dat_wr : i_dat_wr;
    assign bus_rd_adv = spi_sel ? s_rd_adv : i_rd_adv;
    assign bus_wdata  = spi_sel ? s_wdata  : i_wdata;

    cps_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .ptr_wr(bus_ptr_wr), .dat_wr(bus_dat_wr), .rd_adv(bus_rd_adv),
        .wdata(bus_wdata), .ptr(cur_ptr), .regs(cfg_regs)
    );

    // read mux: unimplemented slots return zero
    always_comb begin
        rd_byte = '0;
        for (int k = 0; k < NUM_REGS; k++)
            if (cur_ptr == PTR_W'(k)) rd_byte = cfg_regs[k*8 +: 8];
    end

    assign cp_en = cfg_regs[CPEN_ADDR*8 + CPEN_BIT];
endmodule

// File: rtl/ctrl_port_slave_chk.sv
// Checker for ctrl_port_slave: format latch, pointer rules, enable bit.
// Assumes bus inputs as described in the brief; keeps its own copy of
// the auto-increment flag from observed pointer writes.
module ctrl_port_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_sel,
    input logic       sda_oe,
    input logic [3:0] ptr,
    input logic       ptr_wr,
    input logic       dat_wr,
    input logic       rd_adv,
    input logic [7:0] wdata,
    input logic       cp_en
);
    logic inc_q;

    // shadow of the auto-increment flag
    always_ff @(posedge clk) begin
        if (!rst_n)      inc_q <= 1'b0;
        else if (ptr_wr) inc_q <= wdata[7];
    end

    // R7
    spi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sel |=> spi_sel);

    // R7
    spi_quiet_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(spi_sel) |-> !sda_oe);

    // R4
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wr |=> (ptr == $past(wdata[3:0])));

    // R4
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_wr && !inc_q) |=> $stable(ptr));

    // R4
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_wr && inc_q && (dat_wr || rd_adv) && ptr == 4'hF) |=> (ptr == 4'h0));

    // R10
    cpen_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cp_en) |-> $past(dat_wr));
endmodule

bind ctrl_port_slave ctrl_port_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .spi_sel(spi_sel), .sda_oe(sda_oe),
    .ptr(cur_ptr), .ptr_wr(bus_ptr_wr), .dat_wr(bus_dat_wr),
    .rd_adv(bus_rd_adv), .wdata(bus_wdata), .cp_en(cp_en)
);

// File: tb/ctrl_port_slave_bench.sv
module ctrl_port_slave_bench;
    localparam int NREG = 8;
    localparam int H    = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl = 1'b1, host_low = 1'b0, ad0 = 1'b0, ad1 = 1'b1;
    logic sda_oe, spi_dout, spi_sel, cp_en;
    logic [NREG*8-1:0] cfg;
    wire  sda_line = !(host_low || sda_oe);

    int tests = 0, fails = 0;
    bit finished = 0;
    logic [7:0] exp_reg [16];
    int exp_ptr = 0;
    bit exp_inc = 0;

    always #10 clk = ~clk;

    ctrl_port_slave u_ctrl_port_slave (
        .clk(clk), .rst_n(rst_n), .scl(scl), .sda_in(sda_line),
        .sda_oe(sda_oe), .ad0_cs(ad0), .ad1(ad1), .spi_dout(spi_dout),
        .spi_sel(spi_sel), .cp_en(cp_en), .cfg_regs(cfg)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic m_ptr(input logic [7:0] b);
        exp_inc = b[7];
        exp_ptr = int'(b[3:0]);
    endtask

    task automatic m_wr(input logic [7:0] b);
        if (exp_ptr < NREG) exp_reg[exp_ptr] = b;
        if (exp_inc) exp_ptr = (exp_ptr + 1) % 16;
    endtask

    task automatic m_rd(output logic [7:0] v);
        v = (exp_ptr < NREG) ? exp_reg[exp_ptr] : 8'h00;
        if (exp_inc) exp_ptr = (exp_ptr + 1) % 16;
    endtask

    task automatic check_regs(input string req);
        for (int s = 0; s < NREG; s++)
            check(cfg[s*8 +: 8] == exp_reg[s], req, int'(cfg[s*8 +: 8]), int'(exp_reg[s]));
        check(cp_en == exp_reg[7][7], "R10", int'(cp_en), int'(exp_reg[7][7]));
    endtask

    task automatic i2c_start();
        host_low = 1'b0; tick(H);
        scl = 1'b1; tick(H);
        host_low = 1'b1; tick(H);
        scl = 1'b0; tick(H);
    endtask

    task automatic i2c_stop();
        host_low = 1'b1; tick(H);
        scl = 1'b1; tick(H);
        host_low = 1'b0; tick(H);
    endtask

    task automatic i2c_wr(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            host_low = !b[i]; tick(H);
            scl = 1'b1; tick(H);
            scl = 1'b0;
        end
        host_low = 1'b0; tick(H);
        scl = 1'b1; tick(H/2);
        ack = !sda_line; tick(H/2);
        scl = 1'b0; tick(2);
    endtask

    task automatic i2c_rd(output logic [7:0] b, input bit more);
        host_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(H);
            scl = 1'b1; tick(H/2);
            b[i] = sda_line; tick(H/2);
            scl = 1'b0;
        end
        host_low = more; tick(H);
        scl = 1'b1; tick(H);
        scl = 1'b0; tick(2);
        host_low = 1'b0;
    endtask

    task automatic spi_byte(input logic [7:0] o, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            host_low = !o[i]; tick(H);
            r[i] = spi_dout;
            scl = 1'b1; tick(H);
            scl = 1'b0;
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        bit ack;
        logic [7:0] b, e;
        for (int s = 0; s < 16; s++) exp_reg[s] = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R1 reset state
        check(cfg == '0, "R1", int'(cfg[31:0]), 0);
        check(cp_en == 1'b0, "R1", int'(cp_en), 0);
        check(sda_oe == 1'b0, "R1", int'(sda_oe), 0);
        check(spi_sel == 1'b0, "R1", int'(spi_sel), 0);
        check(spi_dout == 1'b0, "R1", int'(spi_dout), 0);

        // R2 sweep every 7-bit address; only 0x4E (ad1=1, ad0=0) answers
        for (int a = 0; a < 128; a++) begin
            i2c_start();
            i2c_wr({a[6:0], 1'b0}, ack);
            i2c_stop();
            check(ack == (a == 8'h4E), "R2", int'(ack), int'(a == 8'h4E));
        end
        check_regs("R2");

        // R3 R4 R6 burst from slot 6 with auto-increment, wrapping past 15
        i2c_start();
        i2c_wr(8'h9C, ack); check(ack, "R3", int'(ack), 1);
        i2c_wr(8'h86, ack); check(ack, "R3", int'(ack), 1);
        m_ptr(8'h86);
        for (int i = 0; i < 12; i++) begin
            b = 8'(i * 29 + 8'h91);
            i2c_wr(b, ack); check(ack, "R3", int'(ack), 1);
            m_wr(b);
        end
        i2c_stop();
        check_regs("R4");

        // R4 hold: inc=0, value sweep into slot 3, reserved bits set
        i2c_start();
        i2c_wr(8'h9C, ack);
        i2c_wr(8'h73, ack); m_ptr(8'h73);
        for (int i = 0; i < 32; i++) begin
            b = 8'(i * 37 + 11);
            i2c_wr(b, ack); m_wr(b);
            check(cfg[3*8 +: 8] == b, "R4", int'(cfg[3*8 +: 8]), int'(b));
        end
        i2c_stop();
        check_regs("R4");

        // R5 R6 read 20 bytes from slot 0 with increment, repeated start
        i2c_start();
        i2c_wr(8'h9C, ack);
        i2c_wr(8'h80, ack); m_ptr(8'h80);
        i2c_start();
        i2c_wr(8'h9D, ack); check(ack, "R5", int'(ack), 1);
        for (int i = 0; i < 20; i++) begin
            i2c_rd(b, i != 19);
            m_rd(e);
            check(b == e, "R5", int'(b), int'(e));
        end
        i2c_stop();

        // R4 R5 read with increment off returns the same slot
        i2c_start();
        i2c_wr(8'h9C, ack);
        i2c_wr(8'h05, ack); m_ptr(8'h05);
        i2c_start();
        i2c_wr(8'h9D, ack);
        for (int i = 0; i < 3; i++) begin
            i2c_rd(b, i != 2);
            m_rd(e);
            check(b == e, "R4", int'(b), int'(e));
        end
        i2c_stop();

        // R10 clear then set the enable bit in slot 7
        i2c_start();
        i2c_wr(8'h9C, ack);
        i2c_wr(8'h07, ack); m_ptr(8'h07);
        i2c_wr(8'h00, ack); m_wr(8'h00);
        check(cp_en == 1'b0, "R10", int'(cp_en), 0);
        i2c_wr(8'h80, ack); m_wr(8'h80);
        check(cp_en == 1'b1, "R10", int'(cp_en), 1);
        i2c_stop();

        // R7 rising edge alone keeps I2C; falling edge selects SPI
        ad0 = 1'b1; tick(H);
        check(spi_sel == 1'b0, "R7", int'(spi_sel), 0);
        ad0 = 1'b0; tick(H);
        check(spi_sel == 1'b1, "R7", int'(spi_sel), 1);
        ad0 = 1'b1; tick(H);
        check(spi_sel == 1'b1, "R7", int'(spi_sel), 1);

        // R7 I2C traffic in SPI mode is not acknowledged and writes nothing
        i2c_start();
        i2c_wr(8'h9E, ack); check(!ack, "R7", int'(ack), 0);
        i2c_wr(8'h81, ack);
        i2c_wr(8'h3C, ack);
        i2c_stop();
        check_regs("R7");

        // R8 SPI write frame: pointer 0x81, three data bytes
        scl = 1'b0; host_low = 1'b0; tick(H);
        ad0 = 1'b0; tick(H);
        spi_byte(8'h9C, b);
        spi_byte(8'h81, b); m_ptr(8'h81);
        for (int i = 0; i < 3; i++) begin
            spi_byte(8'h5A + 8'(i * 17), b);
            m_wr(8'h5A + 8'(i * 17));
        end
        tick(H); ad0 = 1'b1; tick(2*H);
        check_regs("R8");

        // R8 wrong chip address frame is ignored
        ad0 = 1'b0; tick(H);
        spi_byte(8'h98, b);
        spi_byte(8'h81, b);
        spi_byte(8'hEE, b);
        tick(H); ad0 = 1'b1; tick(2*H);
        check_regs("R8");

        // R9 R6 SPI read from slot 0 with increment, across unimplemented slots
        ad0 = 1'b0; tick(H);
        spi_byte(8'h9C, b);
        spi_byte(8'h80, b); m_ptr(8'h80);
        tick(H); ad0 = 1'b1; tick(2*H);
        ad0 = 1'b0; tick(H);
        spi_byte(8'h9D, b);
        for (int i = 0; i < 10; i++) begin
            spi_byte(8'h00, b);
            m_rd(e);
            check(b == e, "R9", int'(b), int'(e));
        end
        tick(H); ad0 = 1'b1; tick(2*H);
        check(spi_sel == 1'b1, "R7", int'(spi_sel), 1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule